// File: doc/BRIEF.md
# Multiplexed Half-Word Data Port

This block is the digital side of a converter data interface that moves 12-bit samples across 6-bit buses. The bus clock runs at twice the sample rate, so in the normal multiplexed format every sample takes two consecutive transfers: the upper half first, then the lower half. A word-framing strobe goes with the upper half in both directions. On the transmit path the host drives the strobe and the block rebuilds whole words from the half pairs. On the receive path the block splits each converter word into halves and drives the strobe for the host.

A single mode input selects a direct format instead. In that format every 6-bit transfer is a complete sample, placed in the upper bits of a 12-bit word with zero below. The transmit side checks the host's framing and records any strobe that is missing or out of place in a flag that stays set until reset. The receive outputs come from registers, so data and strobe change on the same clock edge.

Top module: `hwport_top`

## Requirements
- R1: While reset is held and in the first cycle after it, tx_word, tx_word_valid, tx_frame_err, rx_bus and rx_sync are all zero.
- R2: In multiplexed format (direct_mode=0) the host drives tx_sync=1 with the upper half and tx_sync=0 with the lower half on the next cycle. On the clock edge that samples the lower half, tx_word becomes {upper, lower} and tx_word_valid is 1 for that one cycle. It is 0 on the edge that samples an upper half.
- R3: A tx_sync=1 in the cycle where a lower half is expected is a misplaced strobe. It sets tx_frame_err, produces no word, and starts a new word, so the bus value in that cycle becomes the upper half.
- R4: Once a first strobe has been seen since reset or since the last direct-format cycle, a cycle with tx_sync=0 where an upper half is expected is a missing strobe. It sets tx_frame_err and produces no word.
- R5: tx_frame_err stays 1 until reset, and words keep being assembled while it is set.
- R6: In direct format (direct_mode=1) every cycle gives tx_word={tx_bus, 6'b0} with tx_word_valid=1 on the next edge. tx_sync is ignored and tx_frame_err does not change.
- R7: In multiplexed format, a cycle with rx_word_stb=1 gives rx_bus=rx_word[11:6] and rx_sync=1 after the next edge. After the edge that follows, rx_bus=rx_word[5:0] and rx_sync=0. Data and strobe change on the same edge.
- R8: In multiplexed format, an rx_word_stb that arrives while a lower half is still pending takes priority: the pending lower half is dropped and the new word's upper half is sent with rx_sync=1.
- R9: In direct format each rx_word_stb sends only rx_word[11:6] with rx_sync=1. The lower six bits are never put on rx_bus.
- R10: One cycle of direct format clears transmit alignment. A multiplexed cycle that follows it with tx_sync=0 gives neither a word nor an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, twice the word rate |
| rst_n | input | 1 | Active-low synchronous reset |
| direct_mode | input | 1 | 1 = direct 6-bit format, 0 = two transfers per word |
| tx_bus | input | 6 | Transmit half-word from the host |
| tx_sync | input | 1 | Host word strobe, high with the upper half |
| tx_word | output | 12 | Reassembled transmit word |
| tx_word_valid | output | 1 | One-cycle marker for a new tx_word |
| tx_frame_err | output | 1 | Sticky framing-error flag |
| rx_word | input | 12 | Receive word from the converter side |
| rx_word_stb | input | 1 | New receive word present on rx_word |
| rx_bus | output | 6 | Receive half-word to the host |
| rx_sync | output | 1 | Receive word strobe, high with the upper half |

## Verification
The bench builds the block with its default half width of six bits, so each word has 4096 values. At that width both paths can be swept over every value. Every 12-bit word goes through the multiplexed transmit and receive paths, and every 6-bit value goes through the direct formats, with the expected results built from shifts and concatenations. Directed sequences cover the strobe faults, the sticky flag, the receive restart case and the alignment clear on a format change.

// File: rtl/hwport_pkg.sv
package hwport_pkg;

    typedef enum logic {
        SLOT_UPPER = 1'b0,
        SLOT_LOWER = 1'b1
    } half_slot_e;

endpackage

// File: rtl/hwport_tx_deframer.sv
module hwport_tx_deframer
    import hwport_pkg::*;
#(
    parameter int HALF_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  direct_mode,
    input  logic [HALF_W-1:0]     bus_in,
    input  logic                  sync_in,
    output logic [2*HALF_W-1:0]   word_out,
    output logic                  word_valid,
    output logic                  frame_err
);

    localparam int WORD_W = 2 * HALF_W;

    typedef struct packed {
        logic [HALF_W-1:0] upper;
        half_slot_e        slot;
        logic              locked;
        logic [WORD_W-1:0] word;
        logic              vld;
        logic              err;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (direct_mode) begin
            st_d.slot   = SLOT_UPPER;
            st_d.locked = 1'b0;
            st_d.word   = {bus_in, {HALF_W{1'b0}}};
            st_d.vld    = 1'b1;
        end else if (sync_in) begin
            if (st_q.slot == SLOT_LOWER) begin
                st_d.err = 1'b1;
            end
            st_d.upper  = bus_in;
            st_d.slot   = SLOT_LOWER;
            st_d.locked = 1'b1;
        end else if (st_q.slot == SLOT_LOWER) begin
            st_d.word = {st_q.upper, bus_in};
            st_d.vld  = 1'b1;
            st_d.slot = SLOT_UPPER;
        end else if (st_q.locked) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_out   = st_q.word;
    assign word_valid = st_q.vld;
    assign frame_err  = st_q.err;

endmodule

// File: rtl/hwport_rx_framer.sv
module hwport_rx_framer #(
    parameter int HALF_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  direct_mode,
    input  logic [2*HALF_W-1:0]   word_in,
    input  logic                  word_stb,
    output logic [HALF_W-1:0]     bus_out,
    output logic                  sync_out
);

    typedef struct packed {
        logic [HALF_W-1:0] bus;
        logic              sync;
        logic [HALF_W-1:0] lower;
        logic              pending;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = 1'b0;
        if (word_stb) begin
            st_d.bus     = word_in[2*HALF_W-1:HALF_W];
            st_d.sync    = 1'b1;
            st_d.lower   = word_in[HALF_W-1:0];
            st_d.pending = !direct_mode;
        end else if (st_q.pending) begin
            st_d.bus     = st_q.lower;
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_out  = st_q.bus;
    assign sync_out = st_q.sync;

endmodule

// File: rtl/hwport_top.sv
module hwport_top #(
    parameter int HALF_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  direct_mode,
    input  logic [HALF_W-1:0]     tx_bus,
    input  logic                  tx_sync,
    output logic [2*HALF_W-1:0]   tx_word,
    output logic                  tx_word_valid,
    output logic                  tx_frame_err,
    input  logic [2*HALF_W-1:0]   rx_word,
    input  logic                  rx_word_stb,
    output logic [HALF_W-1:0]     rx_bus,
    output logic                  rx_sync
);

    hwport_tx_deframer #(.HALF_W(HALF_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .direct_mode (direct_mode),
        .bus_in      (tx_bus),
        .sync_in     (tx_sync),
        .word_out    (tx_word),
        .word_valid  (tx_word_valid),
        .frame_err   (tx_frame_err)
    );

    hwport_rx_framer #(.HALF_W(HALF_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .direct_mode (direct_mode),
        .word_in     (rx_word),
        .word_stb    (rx_word_stb),
        .bus_out     (rx_bus),
        .sync_out    (rx_sync)
    );

endmodule

// File: rtl/hwport_checker.sv
module hwport_checker #(
    parameter int HALF_W = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  direct_mode,
    input logic [HALF_W-1:0]     tx_bus,
    input logic                  tx_sync,
    input logic [2*HALF_W-1:0]   tx_word,
    input logic                  tx_word_valid,
    input logic                  tx_frame_err,
    input logic [2*HALF_W-1:0]   rx_word,
    input logic                  rx_word_stb,
    input logic [HALF_W-1:0]     rx_bus,
    input logic                  rx_sync
);

    // R2: a multiplexed word follows a strobed cycle and then an unstrobed one
    a_r2_word_framing: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_word_valid && !$past(direct_mode)) |-> (!$past(tx_sync) && $past(tx_sync, 2)));

    // R5: the framing flag never clears outside reset
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame_err |=> tx_frame_err);

    // R6: direct samples land in the upper half with zero below
    a_r6_direct_word: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_word_valid && $past(direct_mode)) |->
            (tx_word[HALF_W-1:0] == '0 && tx_word[2*HALF_W-1:HALF_W] == $past(tx_bus)));

    // R6: a framing error can only arise from a multiplexed cycle
    a_r6_no_err_direct: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_frame_err) |-> !$past(direct_mode));

    // R7: the strobe goes out with the upper half of the latched word
    a_r7_rx_upper: assert property (@(posedge clk) disable iff (!rst_n)
        rx_word_stb |=> (rx_sync && rx_bus == $past(rx_word[2*HALF_W-1:HALF_W])));

    // R7: the lower half follows, strobe low
    a_r7_rx_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_word_stb && $past(rx_word_stb) && !$past(direct_mode)) |=>
            (!rx_sync && rx_bus == $past(rx_word[HALF_W-1:0], 2)));

    // R9: in direct format the receive bus holds after the upper half
    a_r9_rx_direct_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_word_stb && $past(rx_word_stb) && $past(direct_mode)) |=>
            (!rx_sync && $stable(rx_bus)));

endmodule

bind hwport_top hwport_checker #(.HALF_W(HALF_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .direct_mode   (direct_mode),
    .tx_bus        (tx_bus),
    .tx_sync       (tx_sync),
    .tx_word       (tx_word),
    .tx_word_valid (tx_word_valid),
    .tx_frame_err  (tx_frame_err),
    .rx_word       (rx_word),
    .rx_word_stb   (rx_word_stb),
    .rx_bus        (rx_bus),
    .rx_sync       (rx_sync)
);

// File: tb/hwport_top_test.sv
module hwport_top_test;

    localparam int HW = 6;
    localparam int WW = 2 * HW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          direct_mode;
    logic [HW-1:0] tx_bus;
    logic          tx_sync;
    logic [WW-1:0] tx_word;
    logic          tx_word_valid;
    logic          tx_frame_err;
    logic [WW-1:0] rx_word;
    logic          rx_word_stb;
    logic [HW-1:0] rx_bus;
    logic          rx_sync;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hwport_top #(.HALF_W(HW)) uut (
        .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode),
        .tx_bus(tx_bus), .tx_sync(tx_sync), .tx_word(tx_word),
        .tx_word_valid(tx_word_valid), .tx_frame_err(tx_frame_err),
        .rx_word(rx_word), .rx_word_stb(rx_word_stb),
        .rx_bus(rx_bus), .rx_sync(rx_sync)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; direct_mode = 1'b0; tx_bus = '0; tx_sync = 1'b0;
        rx_word = '0; rx_word_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_tx(input logic [HW-1:0] v, input logic s);
        tx_bus = v; tx_sync = s;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state (as released and one edge later)
        chk(tx_word == 0 && !tx_word_valid && !tx_frame_err && rx_bus == 0 && !rx_sync,
            "R1 reset outputs", {tx_word, rx_bus}, 0);
        @(negedge clk);
        chk(tx_word == 0 && !tx_word_valid && !tx_frame_err && rx_bus == 0 && !rx_sync,
            "R1 first cycle", {tx_word, rx_bus}, 0);

        // R2: every 12-bit word through the multiplexed transmit path
        for (int w = 0; w < 4096; w++) begin
            send_tx(w[11:6], 1'b1);
            chk(!tx_word_valid, "R2 no word on upper edge", tx_word_valid, 0);
            send_tx(w[5:0], 1'b0);
            chk(tx_word_valid && tx_word == w[11:0], "R2 assembled word", tx_word, w);
        end
        chk(!tx_frame_err, "R2 clean stream no error", tx_frame_err, 0);

        // R3: misplaced strobe realigns and flags
        do_reset();
        send_tx(6'h2A, 1'b1);
        send_tx(6'h15, 1'b1);
        chk(tx_frame_err && !tx_word_valid, "R3 misplaced strobe", {tx_frame_err, tx_word_valid}, 2);
        send_tx(6'h33, 1'b0);
        chk(tx_word_valid && tx_word == 12'h573, "R3 realigned word", tx_word, 12'h573);
        // R5: flag held while words continue
        send_tx(6'h01, 1'b1);
        send_tx(6'h02, 1'b0);
        chk(tx_frame_err && tx_word_valid && tx_word == 12'h042, "R5 sticky flag", {tx_frame_err, tx_word}, 13'h1042);
        repeat (5) begin
            send_tx(6'h3F, 1'b1);
            send_tx(6'h00, 1'b0);
        end
        chk(tx_frame_err, "R5 still set", tx_frame_err, 1);

        // R4: missing strobe after lock
        do_reset();
        send_tx(6'h01, 1'b1);
        send_tx(6'h02, 1'b0);
        chk(tx_word_valid && tx_word == 12'h042 && !tx_frame_err, "R4 good word first", tx_word, 12'h042);
        send_tx(6'h3F, 1'b0);
        chk(tx_frame_err && !tx_word_valid, "R4 missing strobe", {tx_frame_err, tx_word_valid}, 2);

        // R4: no strobe ever seen -> no error
        do_reset();
        repeat (4) send_tx(6'h3F, 1'b0);
        chk(!tx_frame_err && !tx_word_valid, "R4 idle before lock", {tx_frame_err, tx_word_valid}, 0);

        // R6: direct transmit, all 6-bit values, strobe toggled
        do_reset();
        direct_mode = 1'b1;
        for (int v = 0; v < 64; v++) begin
            send_tx(v[5:0], v[0]);
            chk(tx_word_valid && tx_word == {v[5:0], 6'b0}, "R6 direct word", tx_word, {v[5:0], 6'b0});
        end
        chk(!tx_frame_err, "R6 strobe ignored", tx_frame_err, 0);

        // R10: direct cycle clears alignment
        do_reset();
        send_tx(6'h11, 1'b1);
        direct_mode = 1'b1;
        send_tx(6'h05, 1'b0);
        chk(tx_word_valid && tx_word == 12'h140, "R10 direct cycle word", tx_word, 12'h140);
        direct_mode = 1'b0;
        send_tx(6'h07, 1'b0);
        chk(!tx_word_valid && !tx_frame_err, "R10 alignment cleared", {tx_word_valid, tx_frame_err}, 0);

        // R7: every word through the multiplexed receive path
        do_reset();
        for (int w = 0; w < 4096; w++) begin
            rx_word = w[11:0]; rx_word_stb = 1'b1;
            @(negedge clk);
            chk(rx_sync && rx_bus == w[11:6], "R7 upper half", {rx_sync, rx_bus}, {1'b1, w[11:6]});
            rx_word_stb = 1'b0; rx_word = ~w[11:0];
            @(negedge clk);
            chk(!rx_sync && rx_bus == w[5:0], "R7 lower half", {rx_sync, rx_bus}, {1'b0, w[5:0]});
        end

        // R8: back-to-back strobes restart
        rx_word = 12'hABC; rx_word_stb = 1'b1;
        @(negedge clk);
        rx_word = 12'h5D3;
        @(negedge clk);
        chk(rx_sync && rx_bus == 6'h17, "R8 restart upper", {rx_sync, rx_bus}, {1'b1, 6'h17});
        rx_word_stb = 1'b0;
        @(negedge clk);
        chk(!rx_sync && rx_bus == 6'h13, "R8 new lower", {rx_sync, rx_bus}, {1'b0, 6'h13});

        // R9: direct receive, all upper values, lower never shown
        direct_mode = 1'b1;
        for (int v = 0; v < 64; v++) begin
            rx_word = {v[5:0], ~v[5:0]}; rx_word_stb = 1'b1;
            @(negedge clk);
            chk(rx_sync && rx_bus == v[5:0], "R9 direct upper", {rx_sync, rx_bus}, {1'b1, v[5:0]});
        end
        rx_word_stb = 1'b0;
        @(negedge clk);
        chk(!rx_sync && rx_bus == 6'h3F, "R9 no lower half", {rx_sync, rx_bus}, {1'b0, 6'h3F});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule